// File: doc/BRIEF.md
# Relative Countdown Alarm

This block runs an alarm as a relative interval rather than as an absolute time to match. Software loads a countdown split into day, hour, minute and second fields. The block then takes one second off the count on every one-second tick while counting is switched on. Borrows run in mixed radix: seconds and minutes wrap to 59, hours wrap to 23, and days take the final borrow.

When the running count steps from a nonzero value to all zero, the block sets a sticky pending flag. The interrupt line is that flag gated by a separate interrupt enable, so counting and signalling are switched on and off independently. Software clears the flag by writing a one to it.

All state is reached through a small word-wide write port and a combinational read port. The word offsets and field bit positions are fixed, because software packs and unpacks them.

Top module: `rel_alarm`

## Requirements
- R1: After reset the count reads 0, the enable words at 0x14 and 0x18 read 0, the status word at 0x1C reads 0, and `irq` is low.
- R2: The count word at offset 0x0C holds seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days in bits 28:21. A write loads all four fields. A read returns the current count, and every other bit reads 0.
- R3: With bit 8 of the word at 0x14 set, each `sec_tick` pulse lowers the count by one second in mixed radix. Seconds reload to 59 with a borrow from minutes, minutes reload to 59 with a borrow from hours, and hours reload to 23 with a borrow from days.
- R4: While bit 8 of 0x14 is clear, ticks leave the count unchanged, and the held value stays readable.
- R5: On the edge where an enabled tick moves the count from nonzero to zero, the pending flag (bit 0 of 0x1C) sets. A count of zero is never decremented further and never sets the flag again.
- R6: The pending flag stays set until a write to 0x1C with bit 0 at 1. A write with bit 0 at 0 leaves it set.
- R7: `irq` is high exactly when the pending flag is set and bit 0 of 0x18 is set. The interrupt enable has no effect on the flag itself.
- R8: If a clearing write to 0x1C falls in the same cycle as an expiry, the pending flag is left set.
- R9: Writing zero to the count word cancels a countdown in progress, and no expiry follows.
- R10: A count write in the same cycle as an enabled tick loads the written value without decrementing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 5 | Byte offset of the word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sec_tick | input | 1 | One-second tick, one cycle wide |
| irq | output | 1 | Alarm interrupt |

## Verification
Two pairs of functions can land on the same clock edge. A software clear of the pending flag can coincide with the tick that brings the count to zero, and a count write can coincide with an enabled tick. The bench forces each collision by raising `sec_tick` in the very cycle that carries the write.

It then reads back the status and count words. The flag must remain set, and the count must equal the written value with no decrement applied. The sweep over borrow boundaries compares each read against a count computed as total seconds minus ticks.

// File: rtl/rel_alarm_pkg.sv
package rel_alarm_pkg;
  // word offsets (software decodes these)
  localparam int OFS_COUNT  = 'h0C;
  localparam int OFS_ENABLE = 'h14;
  localparam int OFS_IRQEN  = 'h18;
  localparam int OFS_STATUS = 'h1C;

  // field placement in the count word
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HOUR_LSB = 16;
  localparam int DAY_LSB  = 21;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_W   = 5;

  localparam int RUN_BIT   = 8;
  localparam int IRQEN_BIT = 0;
  localparam int PEND_BIT  = 0;

  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HOUR_MAX = 23;

  typedef struct packed {
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } hms_t;
endpackage

// File: rtl/rel_alarm_regs.sv
module rel_alarm_regs
  import rel_alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt_word,
  input  logic              pend,
  output logic              cnt_load,
  output hms_t              load_hms,
  output logic [DAY_W-1:0]  load_day,
  output logic              run_en,
  output logic              irq_en,
  output logic              pend_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(OFS_IRQEN);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  logic run_wr, irqen_wr;
  logic run_q, irqen_q;

  always_comb begin
    cnt_load      = wr_en && (addr == A_COUNT);
    run_wr        = wr_en && (addr == A_ENABLE);
    irqen_wr      = wr_en && (addr == A_IRQEN);
    pend_clr      = wr_en && (addr == A_STATUS) && wdata[PEND_BIT];
    load_hms.sec  = wdata[SEC_LSB  +: SEC_W];
    load_hms.min  = wdata[MIN_LSB  +: MIN_W];
    load_hms.hour = wdata[HOUR_LSB +: HOUR_W];
    load_day      = wdata[DAY_LSB  +: DAY_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (run_wr) begin
      run_q <= wdata[RUN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqen_q <= 1'b0;
    end else if (irqen_wr) begin
      irqen_q <= wdata[IRQEN_BIT];
    end
  end

  assign run_en = run_q;
  assign irq_en = irqen_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_COUNT:  rdata = cnt_word;
      A_ENABLE: rdata[RUN_BIT]   = run_q;
      A_IRQEN:  rdata[IRQEN_BIT] = irqen_q;
      A_STATUS: rdata[PEND_BIT]  = pend;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/rel_alarm_count.sv
module rel_alarm_count
  import rel_alarm_pkg::*;
#(
  parameter int DAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  hms_t             load_hms,
  input  logic [DAY_W-1:0] load_day,
  input  logic             tick,
  input  logic             run,
  output hms_t             hms,
  output logic [DAY_W-1:0] day,
  output logic             expire
);
  hms_t             hms_q, hms_n;
  logic [DAY_W-1:0] day_q, day_n;
  logic             is_zero, is_last, step, upd;

  always_comb begin
    is_zero = (hms_q == '0) && (day_q == '0);
    is_last = (hms_q.sec == SEC_W'(1)) && (hms_q.min == '0) &&
              (hms_q.hour == '0) && (day_q == '0);
    step    = !load && tick && run && !is_zero;
    upd     = load || step;
    expire  = step && is_last;
    hms_n   = hms_q;
    day_n   = day_q;
    if (load) begin
      hms_n = load_hms;
      day_n = load_day;
    end else if (step) begin
      if (hms_q.sec != '0) begin
        hms_n.sec = hms_q.sec - SEC_W'(1);
      end else begin
        hms_n.sec = SEC_W'(SEC_MAX);
        if (hms_q.min != '0) begin
          hms_n.min = hms_q.min - MIN_W'(1);
        end else begin
          hms_n.min = MIN_W'(MIN_MAX);
          if (hms_q.hour != '0) begin
            hms_n.hour = hms_q.hour - HOUR_W'(1);
          end else begin
            hms_n.hour = HOUR_W'(HOUR_MAX);
            day_n      = day_q - DAY_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hms_q <= '0;
      day_q <= '0;
    end else if (upd) begin
      hms_q <= hms_n;
      day_q <= day_n;
    end
  end

  assign hms = hms_q;
  assign day = day_q;
endmodule

// File: rtl/rel_alarm_flag.sv
module rel_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  logic pend_q, pend_n, upd;

  always_comb begin
    upd    = set || clr;
    pend_n = set ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (upd) begin
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/rel_alarm.sv
module rel_alarm
  import rel_alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sec_tick,
  output logic              irq
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              cnt_load, run_en, irq_en, pend_clr, pend, expire;
  hms_t              load_hms, hms;
  logic [DAY_W-1:0]  load_day, day;
  logic [DATA_W-1:0] cnt_word;
  logic              unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  assign unused_wdata = ^reg_wdata;

  always_comb begin
    cnt_word = '0;
    cnt_word[SEC_LSB  +: SEC_W]  = hms.sec;
    cnt_word[MIN_LSB  +: MIN_W]  = hms.min;
    cnt_word[HOUR_LSB +: HOUR_W] = hms.hour;
    cnt_word[DAY_LSB  +: DAY_W]  = day;
  end

  rel_alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DAY_W(DAY_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cnt_word (cnt_word),
    .pend     (pend),
    .cnt_load (cnt_load),
    .load_hms (load_hms),
    .load_day (load_day),
    .run_en   (run_en),
    .irq_en   (irq_en),
    .pend_clr (pend_clr),
    .rdata    (reg_rdata)
  );

  rel_alarm_count #(.DAY_W(DAY_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cnt_load),
    .load_hms (load_hms),
    .load_day (load_day),
    .tick     (sec_tick),
    .run      (run_en),
    .hms      (hms),
    .day      (day),
    .expire   (expire)
  );

  rel_alarm_flag u_flag (
    .clk  (clk),
    .rst_n(rst_int_n),
    .set  (expire),
    .clr  (pend_clr),
    .pend (pend)
  );

  assign irq = pend && irq_en;
endmodule

// File: rtl/rel_alarm_chk.sv
module rel_alarm_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              tick,
  input logic              run,
  input logic [DATA_W-1:0] cnt_word,
  input logic              expire,
  input logic              pend,
  input logic              pend_clr,
  input logic              irq_en,
  input logic              irq
);
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en); // R7
  AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && irq_en) |-> irq); // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !pend_clr) |=> pend); // R6
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && expire) |=> pend); // R8
  AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (pend && cnt_word == '0)); // R5
  AST_ZERO_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_word == '0 && !load) |=> (cnt_word == '0)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && run)) |=> $stable(cnt_word)); // R4
endmodule

bind rel_alarm rel_alarm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .load     (cnt_load),
  .tick     (sec_tick),
  .run      (run_en),
  .cnt_word (cnt_word),
  .expire   (expire),
  .pend     (pend),
  .pend_clr (pend_clr),
  .irq_en   (irq_en),
  .irq      (irq)
);

// File: tb/rel_alarm_bench.sv
`timescale 1ns/1ps
module rel_alarm_bench;
  localparam logic [4:0] A_CNT = 5'h0C, A_EN = 5'h14, A_IE = 5'h18, A_ST = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        sec_tick;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  rel_alarm u_rel_alarm (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick), .irq(irq)
  );

  function automatic logic [31:0] pack(int t);
    int s, m, h, d;
    s = t % 60;
    m = (t / 60) % 60;
    h = (t / 3600) % 24;
    d = t / 86400;
    return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic tick1();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int dl[3] = '{0, 1, 2};
    int hl[3] = '{0, 1, 23};
    int ml[3] = '{0, 1, 59};
    int sl[3] = '{0, 1, 59};
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; sec_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CNT, v); check("R1 count", v, 0);
    rd(A_EN, v);  check("R1 enable", v, 0);
    rd(A_IE, v);  check("R1 irq enable", v, 0);
    rd(A_ST, v);  check("R1 status", v, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 field layout
    wr(A_CNT, 32'hFFFF_FFFF);
    rd(A_CNT, v); check("R2 all-ones readback", v, 32'h1FFF_3F3F);
    wr(A_CNT, pack(2 * 86400 + 5 * 3600 + 7 * 60 + 9));
    rd(A_CNT, v); check("R2 field placement", v, 32'h0045_0709);
    wr(A_CNT, 0);

    // R3 / R5 sweep over borrow boundaries
    wr(A_EN, 32'h100);
    foreach (dl[i]) foreach (hl[j]) foreach (ml[k]) foreach (sl[q]) begin
      int tot = dl[i] * 86400 + hl[j] * 3600 + ml[k] * 60 + sl[q];
      wr(A_ST, 1);
      wr(A_CNT, pack(tot));
      for (int n = 1; n <= 2; n++) begin
        int left = (tot > n) ? tot - n : 0;
        tick1();
        rd(A_CNT, v); check("R3 mixed-radix step", v, pack(left));
        rd(A_ST, v);  check("R5 pending on zero", v, (tot > 0 && tot <= n) ? 1 : 0);
      end
    end

    // R4 hold while disabled
    wr(A_ST, 1);
    wr(A_CNT, pack(10));
    wr(A_EN, 0);
    tick1(); tick1(); tick1();
    rd(A_CNT, v); check("R4 held when disabled", v, pack(10));
    wr(A_EN, 32'h100);
    tick1();
    rd(A_CNT, v); check("R4 resumes", v, pack(9));

    // R5 full run, R7 flag without irq enable
    wr(A_CNT, pack(70));
    for (int n = 1; n <= 70; n++) begin
      tick1();
      rd(A_ST, v);
      if (n >= 69) check("R5 set exactly at zero", v, (n == 70) ? 1 : 0);
      else if (v != 0) check("R5 early pending", v, 0);
    end
    check("R7 irq masked", 32'(irq), 0);
    tick1(); tick1(); tick1();
    rd(A_CNT, v); check("R5 stays at zero", v, 0);
    rd(A_ST, v);  check("R5 still pending", v, 1);

    // R6 write-one-to-clear
    wr(A_ST, 0);
    rd(A_ST, v); check("R6 zero write ignored", v, 1);
    wr(A_ST, 1);
    rd(A_ST, v); check("R6 clear", v, 0);

    // R7 irq gating
    wr(A_IE, 1);
    check("R7 no pend no irq", 32'(irq), 0);
    wr(A_CNT, pack(1));
    tick1();
    check("R7 irq raised", 32'(irq), 1);
    wr(A_IE, 0);
    check("R7 irq masked", 32'(irq), 0);
    rd(A_ST, v); check("R7 enable leaves flag", v, 1);
    wr(A_IE, 1);
    check("R7 irq back", 32'(irq), 1);
    wr(A_ST, 1);
    check("R7 irq after clear", 32'(irq), 0);

    // R8 clear and expiry in the same cycle
    wr(A_CNT, pack(1));
    tick1();
    wr(A_CNT, pack(1));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 1; sec_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; sec_tick = 1'b0;
    rd(A_ST, v);  check("R8 expiry beats clear", v, 1);
    rd(A_CNT, v); check("R8 count zero", v, 0);
    wr(A_ST, 1);

    // R9 zero write cancels
    wr(A_CNT, pack(5));
    tick1(); tick1();
    wr(A_CNT, 0);
    repeat (5) tick1();
    rd(A_ST, v);  check("R9 no expiry", v, 0);
    rd(A_CNT, v); check("R9 count cleared", v, 0);
    check("R9 irq low", 32'(irq), 0);

    // R10 write collides with tick
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CNT; reg_wdata = pack(8); sec_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; sec_tick = 1'b0;
    rd(A_CNT, v); check("R10 load wins over tick", v, pack(8));
    tick1();
    rd(A_CNT, v); check("R10 next tick decrements", v, pack(7));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule